// File: doc/BRIEF.md
# SPI Mode-1 Register Target

This block is an SPI target that sits entirely inside one local system-clock domain. The select, serial clock and data-in pins are oversampled by that clock through small synchronizer chains. Edges are found by comparing each synchronized level with its value one cycle earlier. The serial clock idles low. The target changes its output bit on each rising serial-clock edge and samples the incoming bit on each falling edge, which is SPI mode 1.

Each transaction exchanges one word of `WORD_W` bits, most-significant bit first in both directions. When select falls, the block takes a snapshot of the parallel read word and shifts that snapshot out. When select rises, the bits received so far are copied to the parallel write output, and a one-cycle done strobe marks the update. The system clock should run at least eight times faster than the serial clock, so that each half period of the serial clock covers the synchronizer latency.

Top module: `spi_m1_target`

## Requirements
- R1: While reset is high, and after it is released with no traffic, `wr_word_o` is 0, `wr_done_o` is 0 and `miso_o` is 0. Reset is asynchronous.
- R2: While select is high, `miso_o` is 0 once the synchronized select has risen, which takes at most three system-clock cycles.
- R3: The transmit word is the value of `rd_word_i` when the falling edge of select is detected. Later changes to `rd_word_i` during the transaction have no effect on MISO.
- R4: On the k-th rising serial-clock edge of a transaction, MISO presents bit `WORD_W-k` of the captured word. This sends the MSB first. Rising edges beyond `WORD_W` present 0. Before the first rising edge, MISO is 0.
- R5: On each falling serial-clock edge while selected, MOSI is shifted into the LSB of the receive register. After n falling edges, the received word equals the last `min(n, WORD_W)` bits sent, with the last bit in bit 0.
- R6: In a transaction with fewer than `WORD_W` falling edges, the bits received are zero-extended, because the receive register is cleared when select falls.
- R7: `wr_word_o` changes only in the cycle in which `wr_done_o` is high. It holds its value between transactions.
- R8: Every rising edge of select produces exactly one `wr_done_o` pulse, one system-clock cycle wide. The pulse comes together with the new `wr_word_o`.
- R9: Serial-clock edges while select is high do not alter `wr_word_o`, do not raise `wr_done_o`, and do not disturb the next transaction.
- R10: `WORD_W` must be at least 1 and the synchronizer depth at least 2. The block works at `WORD_W = 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| sel_n_i | input | 1 | SPI select, active low |
| sck_i | input | 1 | SPI serial clock, idles low |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data to the controller |
| rd_word_i | input | WORD_W | Parallel word to transmit |
| wr_word_o | output | WORD_W | Last received word |
| wr_done_o | output | 1 | One-cycle strobe marking a new write word |

## Verification
The assertions check, on every cycle, the rules that need only one or two cycles of history:
- the done strobe is one cycle wide and follows a detected select rise;
- the write word is stable outside the strobe;
- the transmit snapshot equals the read word present at the select fall;
- each shift in or out moves the bit that was present the cycle before.

Only the bench scenarios can show the end-to-end behaviour:
- the round-trip data at word sizes 1, 8 and 13;
- zero-extension of short transfers;
- that a read word changed in mid-transaction is ignored;
- that serial-clock activity with select high leaves the write word untouched.

// File: rtl/spi_m1_pkg.sv
package spi_m1_pkg;

   // Synchronized level of one pin plus its detected edges.
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/spi_m1_sync_edge.sv
module spi_m1_sync_edge
   import spi_m1_pkg::*;
#(
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic  clk_i,
   input  logic  rst_i,
   input  logic  d_i,
   output edge_t ev_o
);

   localparam int LAST = STAGES - 1;

   // R10: a chain shorter than two flops gives no metastability margin
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_m1_sync_edge: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[LAST-1:0], d_i};
         prev_q  <= chain_q[LAST];
      end
   end

   always_comb begin
      ev_o.lvl  = chain_q[LAST];
      ev_o.rise = chain_q[LAST] & ~prev_q;
      ev_o.fall = ~chain_q[LAST] & prev_q;
   end

endmodule

// File: rtl/spi_m1_tx.sv
module spi_m1_tx #(
   parameter int WORD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              sel_fall_i,
   input  logic              active_i,
   input  logic              sck_rise_i,
   input  logic [WORD_W-1:0] rd_word_i,
   output logic              bit_o
);

   localparam int MSB = WORD_W - 1;

   logic [MSB:0] tx_sr_q;
   logic         bit_q;
   logic [MSB:0] tx_next;

   // Shift left and fill with zeros; a 1-bit word simply empties.
   if (WORD_W == 1) begin : g_one
      assign tx_next = 1'b0;
   end else begin : g_many
      assign tx_next = {tx_sr_q[MSB-1:0], 1'b0};
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         tx_sr_q <= '0;
         bit_q   <= 1'b0;
      end else if (sel_fall_i) begin
         tx_sr_q <= rd_word_i;
         bit_q   <= 1'b0;
      end else if (active_i && sck_rise_i) begin
         bit_q   <= tx_sr_q[MSB];
         tx_sr_q <= tx_next;
      end
   end

   assign bit_o = bit_q;

   a_r3_snapshot: assert property (@(posedge clk_i) disable iff (rst_i)
      sel_fall_i |=> (tx_sr_q == $past(rd_word_i)));

   a_r4_shift_out: assert property (@(posedge clk_i) disable iff (rst_i)
      (active_i && sck_rise_i && !sel_fall_i) |=> (bit_q == $past(tx_sr_q[MSB])));

endmodule

// File: rtl/spi_m1_rx.sv
module spi_m1_rx #(
   parameter int WORD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              sel_fall_i,
   input  logic              sel_rise_i,
   input  logic              active_i,
   input  logic              sck_fall_i,
   input  logic              mosi_i,
   output logic [WORD_W-1:0] wr_word_o,
   output logic              done_o
);

   localparam int MSB = WORD_W - 1;

   logic [MSB:0] rx_sr_q;
   logic [MSB:0] rx_next;
   logic [MSB:0] wr_q;
   logic         done_q;

   if (WORD_W == 1) begin : g_one
      assign rx_next = mosi_i;
   end else begin : g_many
      assign rx_next = {rx_sr_q[MSB-1:0], mosi_i};
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         rx_sr_q <= '0;
      end else if (sel_fall_i) begin
         rx_sr_q <= '0;
      end else if (active_i && sck_fall_i) begin
         rx_sr_q <= rx_next;
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         wr_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= sel_rise_i;
         if (sel_rise_i) wr_q <= rx_sr_q;
      end
   end

   assign wr_word_o = wr_q;
   assign done_o    = done_q;

   a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
      done_q |=> !done_q);

   a_r8_done_after_rise: assert property (@(posedge clk_i) disable iff (rst_i)
      done_q |-> $past(sel_rise_i));

   a_r7_wr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !done_q |-> $stable(wr_q));

   a_r5_shift_in: assert property (@(posedge clk_i) disable iff (rst_i)
      (active_i && sck_fall_i && !sel_fall_i) |=> (rx_sr_q[0] == $past(mosi_i)));

endmodule

// File: rtl/spi_m1_target.sv
module spi_m1_target
   import spi_m1_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              sel_n_i,
   input  logic              sck_i,
   input  logic              mosi_i,
   output logic              miso_o,
   input  logic [WORD_W-1:0] rd_word_i,
   output logic [WORD_W-1:0] wr_word_o,
   output logic              wr_done_o
);

   // R10: elaboration-time parameter checks
   if (WORD_W < 1) begin : g_bad_width
      $error("spi_m1_target: WORD_W must be at least 1");
   end

   edge_t sel_ev, sck_ev, mosi_ev;
   logic  active;
   logic  tx_bit;

   spi_m1_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(sel_n_i), .ev_o(sel_ev));

   spi_m1_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(sck_i), .ev_o(sck_ev));

   spi_m1_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(mosi_i), .ev_o(mosi_ev));

   assign active = ~sel_ev.lvl;

   spi_m1_tx #(.WORD_W(WORD_W)) u_tx (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .sel_fall_i (sel_ev.rise == 1'b0 && sel_ev.fall),
      .active_i   (active),
      .sck_rise_i (sck_ev.rise),
      .rd_word_i  (rd_word_i),
      .bit_o      (tx_bit));

   spi_m1_rx #(.WORD_W(WORD_W)) u_rx (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .sel_fall_i (sel_ev.fall),
      .sel_rise_i (sel_ev.rise),
      .active_i   (active),
      .sck_fall_i (sck_ev.fall),
      .mosi_i     (mosi_ev.lvl),
      .wr_word_o  (wr_word_o),
      .done_o     (wr_done_o));

   assign miso_o = active & tx_bit;

   // R2: two cycles after synchronized select goes inactive, MISO is quiet
   a_r2_miso_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_ev.lvl && $past(sel_ev.lvl)) |-> !miso_o);

endmodule

// File: tb/spi_m1_target_bench.sv
module spi_m1_target_bench;

   localparam int CLK_P = 10;
   localparam int HALF  = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sel_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;

   logic [31:0] rd_a, rd_b, rd_c;
   logic        miso_a, miso_b, miso_c;
   logic [7:0]  wr_a;
   logic [0:0]  wr_b;
   logic [12:0] wr_c;
   logic        done_a, done_b, done_c;

   int total = 0;
   int bad   = 0;
   int cnt_a = 0, cnt_b = 0, cnt_c = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   spi_m1_target #(.WORD_W(8)) u_spi_m1_target (
      .clk_i(clk), .rst_i(rst), .sel_n_i(sel_n), .sck_i(sck), .mosi_i(mosi),
      .miso_o(miso_a), .rd_word_i(rd_a[7:0]), .wr_word_o(wr_a), .wr_done_o(done_a));

   spi_m1_target #(.WORD_W(1)) u_spi_m1_target_w1 (
      .clk_i(clk), .rst_i(rst), .sel_n_i(sel_n), .sck_i(sck), .mosi_i(mosi),
      .miso_o(miso_b), .rd_word_i(rd_b[0:0]), .wr_word_o(wr_b), .wr_done_o(done_b));

   spi_m1_target #(.WORD_W(13)) u_spi_m1_target_w13 (
      .clk_i(clk), .rst_i(rst), .sel_n_i(sel_n), .sck_i(sck), .mosi_i(mosi),
      .miso_o(miso_c), .rd_word_i(rd_c[12:0]), .wr_word_o(wr_c), .wr_done_o(done_c));

   always @(negedge clk) begin
      if (done_a) cnt_a <= cnt_a + 1;
      if (done_b) cnt_b <= cnt_b + 1;
      if (done_c) cnt_c <= cnt_c + 1;
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0h expected=%0h at %0t", req, got, exp, $time);
      end
   endtask

   // Expected MISO bit after the k-th rising edge (k from 1) for width w.
   function automatic logic exp_miso(input logic [31:0] word, input int w, input int k);
      if (k > w) return 1'b0;
      return word[w-k];
   endfunction

   // Expected write word: the low w bits of the stream sent.
   function automatic logic [31:0] exp_wr(input logic [31:0] stream, input int w);
      logic [31:0] mask;
      mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      return stream & mask;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Runs one transaction with nbits clocks; when swap is set, the read words
   // change after the select fall has been captured.
   task automatic xfer(input int nbits, input logic [31:0] stream, input bit swap);
      logic [31:0] ca, cb, cc;
      int          sa, sb, sc;
      ca = rd_a; cb = rd_b; cc = rd_c;
      sa = cnt_a; sb = cnt_b; sc = cnt_c;
      @(negedge clk);
      sel_n = 1'b0;
      wait_clk(5);
      if (swap) begin
         rd_a = ~rd_a; rd_b = ~rd_b; rd_c = ~rd_c;
      end
      wait_clk(3);
      for (int i = 1; i <= nbits; i++) begin
         sck  = 1'b1;
         mosi = (stream >> (nbits - i)) & 32'd1;
         wait_clk(HALF);
         check(swap ? "R3 w8" : "R4 w8",  {31'b0, miso_a}, {31'b0, exp_miso(ca, 8, i)});
         check(swap ? "R3 w1" : "R4 w1",  {31'b0, miso_b}, {31'b0, exp_miso(cb, 1, i)});
         check(swap ? "R3 w13" : "R4 w13", {31'b0, miso_c}, {31'b0, exp_miso(cc, 13, i)});
         sck = 1'b0;
         wait_clk(HALF);
      end
      sel_n = 1'b1;
      wait_clk(HALF);
      check("R8 pulses w8",  cnt_a - sa, 1);
      check("R8 pulses w1",  cnt_b - sb, 1);
      check("R8 pulses w13", cnt_c - sc, 1);
      check("R5/R6 w8",  {24'b0, wr_a}, exp_wr(stream, 8));
      check("R5/R6 w1",  {31'b0, wr_b}, exp_wr(stream, 1));
      check("R5/R6 w13", {19'b0, wr_c}, exp_wr(stream, 13));
      check("R2 w8",  {31'b0, miso_a}, 0);
      check("R2 w13", {31'b0, miso_c}, 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      rd_a = 32'hA5; rd_b = 32'h1; rd_c = 32'h1ABC;

      // R1: reset state, during and after reset
      wait_clk(3);
      check("R1 wr", {24'b0, wr_a}, 0);
      check("R1 done", {31'b0, done_a}, 0);
      check("R1 miso", {31'b0, miso_a}, 0);
      rst = 1'b0;
      wait_clk(6);
      check("R1 wr after", {19'b0, wr_c}, 0);
      check("R1 done after", cnt_a + cnt_b + cnt_c, 0);

      // R4/R5: full words, all-ones read word so MISO is 1 at the end (R2)
      rd_a = 32'hFF; rd_c = 32'h1FFF;
      xfer(8, 32'h3C, 1'b0);
      xfer(13, 32'h1234, 1'b0);
      // R10: word size 1 and a longer stream than every width
      xfer(20, 32'hBEEF5, 1'b0);

      // R3: read word changed in mid-transaction
      rd_a = 32'h5A; rd_b = 32'h0; rd_c = 32'h0F0F;
      xfer(13, 32'h0AAA, 1'b1);

      // R6: short transfer zero-extends
      xfer(3, 32'h5, 1'b0);

      // R9 / R7: serial clock while deselected leaves everything alone
      begin
         int s;
         s = cnt_a + cnt_b + cnt_c;
         mosi = 1'b1;
         for (int i = 0; i < 6; i++) begin
            sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
         end
         check("R9 no done", cnt_a + cnt_b + cnt_c - s, 0);
         check("R9 R7 wr w8 held", {24'b0, wr_a}, 32'h5);
         check("R9 R7 wr w13 held", {19'b0, wr_c}, 32'h5);
      end
      xfer(8, 32'h81, 1'b0);

      // random mix
      for (int t = 0; t < 24; t++) begin
         int          n;
         logic [31:0] s;
         n = 1 + int'($urandom_range(19));
         s = $urandom() & ((32'd1 << n) - 32'd1);
         rd_a = $urandom(); rd_b = $urandom(); rd_c = $urandom();
         xfer(n, s, bit'($urandom_range(1)));
      end

      finished = 1'b1;
   end

   initial begin
      while (!finished && cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=%0d expected=finish", cycles);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule